// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Register

This block holds the interrupt state of a timekeeping peripheral. Three single-cycle event strobes (periodic tick, alarm match and update ended) each set a sticky flag. The host reads the flags from the interrupt status register at address 12. A control register at address 11 holds one enable bit per source. The top bit of the status register summarizes the flags whose enable is set, and the level interrupt output follows that summary.

Reading address 12 returns the flags and the summary bit. On the same clock edge the read clears every flag. An event that arrives in the cycle of that read is not lost, because its flag stays set for the next read. A read-only validity register at address 13 reports that RAM and time are valid. The circuits that generate the events and the bus protocol that carries the accesses are outside this block.

Top module: `rtc_intr_status`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every flag, the control byte and `irq` are zero. A read of address 12 returns 0x00 and a read of address 11 returns 0x00.
- R2: A high level on `evt_periodic`, `evt_alarm` or `evt_update` at a clock edge sets the corresponding flag, whether or not its enable is set. The flags appear at address 12 in bit 6 (periodic), bit 5 (alarm) and bit 4 (update ended).
- R3: Bit 7 of address 12 is 1 exactly when some flag is set together with its enable. The enables are bits 6 (periodic), 5 (alarm) and 4 (update ended) of the control byte at address 11. A change of enable takes effect in the cycle after the write.
- R4: `irq` equals bit 7 of address 12. Once high, it stays high until a read of address 12 or a write to address 11 removes the cause.
- R5: A cycle with `bus_rd` high and `bus_addr` = 12 returns the current flags and summary on `bus_rdata` in that cycle, and clears all flags at the following clock edge.
- R6: An event strobe in the same cycle as a clearing read leaves its flag set after that edge. The read itself returns the state from before the event.
- R7: Bits 3:0 of address 12 always read as zero.
- R8: Address 13 always reads 0x80, which marks RAM and time as valid. A write to it has no effect.
- R9: Address 11 stores and returns the full byte that was written. A write to address 12 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | Periodic event strobe |
| evt_alarm | input | 1 | Alarm event strobe |
| evt_update | input | 1 | Update-ended event strobe |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe; a read of address 12 clears the flags |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt request, high while an enabled flag is pending |

## Verification
The hardest case to create from the ports is an event strobe landing in the same cycle as the clearing read. It has to show both the old value on the bus and a flag that survives into the next read. The stimulus sets one flag, then issues the read of address 12 with a different strobe raised in that same cycle, and reads again. The second difficulty is watching `irq` without disturbing the flags, because every read of address 12 destroys them. The bench therefore checks the interrupt level while reading address 13, which has no side effect, and reads address 12 only where a clear is intended.

// File: rtl/rtc_intr_pkg.sv
package rtc_intr_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int N_SRC    = 3;
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = DATA_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd11;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 4'd12;
    localparam logic [ADDR_W-1:0] ADDR_VALID  = 4'd13;

    localparam logic [DATA_W-1:0] VALID_BYTE  = 8'h80;

    // source index order: 2 periodic, 1 alarm, 0 update ended
    typedef enum int {
        SRC_UPDATE   = 0,
        SRC_ALARM    = 1,
        SRC_PERIODIC = 2
    } src_idx_e;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic src_vec_t ctrl_enables(input logic [DATA_W-1:0] ctrl);
        return ctrl[FLAG_LSB +: N_SRC];
    endfunction

    function automatic logic pending(input src_vec_t flags, input src_vec_t en);
        return |(flags & en);
    endfunction

    function automatic logic [DATA_W-1:0] flag_byte(input src_vec_t flags,
                                                    input logic summary);
        logic [DATA_W-1:0] b;
        b = '0;
        b[FLAG_LSB +: N_SRC] = flags;
        b[SUM_BIT] = summary;
        return b;
    endfunction

endpackage

// File: rtl/rtc_intr_flag_bank.sv
module rtc_intr_flag_bank
    import rtc_intr_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            logic held;
            logic nxt;

            // clear drops the old value, a coincident event wins
            always_comb begin
                nxt = (held & ~clr) | evt[i];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    held <= 1'b0;
                end else begin
                    held <= nxt;
                end
            end

            assign flags[i] = held;
        end
    endgenerate

endmodule

// File: rtl/rtc_intr_ctrl_reg.sv
module rtc_intr_ctrl_reg
    import rtc_intr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl
);

    logic [W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wdata;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/rtc_intr_read_mux.sv
module rtc_intr_read_mux
    import rtc_intr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          flags,
    input  logic              summary,
    input  logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (addr)
            ADDR_CTRL:  rdata = ctrl;
            ADDR_FLAGS: rdata = flag_byte(flags, summary);
            ADDR_VALID: rdata = VALID_BYTE;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_intr_status.sv
module rtc_intr_status
    import rtc_intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    bus_req_t          req;
    src_vec_t          evt_vec;
    src_vec_t          flag_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              flag_clr;
    logic              ctrl_wr;
    logic              summary;

    always_comb begin
        req.rd    = bus_rd;
        req.wr    = bus_wr;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
    end

    always_comb begin
        evt_vec = '0;
        evt_vec[SRC_PERIODIC] = evt_periodic;
        evt_vec[SRC_ALARM]    = evt_alarm;
        evt_vec[SRC_UPDATE]   = evt_update;
    end

    assign flag_clr = req.rd && (req.addr == ADDR_FLAGS);
    assign ctrl_wr  = req.wr && (req.addr == ADDR_CTRL);

    rtc_intr_flag_bank #(.N(N_SRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_vec),
        .clr   (flag_clr),
        .flags (flag_q)
    );

    rtc_intr_ctrl_reg #(.W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctrl_wr),
        .wdata (req.wdata),
        .ctrl  (ctrl_q)
    );

    assign summary = pending(flag_q, ctrl_enables(ctrl_q));
    assign irq     = summary;

    rtc_intr_read_mux u_rmux (
        .addr    (req.addr),
        .flags   (flag_q),
        .summary (summary),
        .ctrl    (ctrl_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/rtc_intr_status_chk.sv
module rtc_intr_status_chk
    import rtc_intr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              evt_periodic,
    input logic              evt_alarm,
    input logic              evt_update,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input src_vec_t          flag_q
);

    logic     rd_clr;
    logic     ctl_wr;
    src_vec_t ev;

    assign rd_clr = bus_rd && (bus_addr == ADDR_FLAGS);
    assign ctl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign ev     = {evt_periodic, evt_alarm, evt_update};

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && !irq));

    // R2
    periodic_sets_chk: assert property (@(posedge clk) disable iff (rst)
        evt_periodic |=> flag_q[SRC_PERIODIC]);

    // R2
    alarm_sets_chk: assert property (@(posedge clk) disable iff (rst)
        evt_alarm |=> flag_q[SRC_ALARM]);

    // R2
    update_sets_chk: assert property (@(posedge clk) disable iff (rst)
        evt_update |=> flag_q[SRC_UPDATE]);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && ev == '0) |=> (flag_q == '0));

    // R6
    race_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && ev != '0) |=> ((flag_q & $past(ev)) == $past(ev)));

    // R4
    irq_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_clr && !ctl_wr) |=> irq);

    // R4
    irq_matches_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_FLAGS) |-> (bus_rdata[SUM_BIT] == irq));

    // R7
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_FLAGS) |-> (bus_rdata[FLAG_LSB-1:0] == '0));

    // R8
    valid_const_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_VALID) |-> (bus_rdata == VALID_BYTE));

endmodule

bind rtc_intr_status rtc_intr_status_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .irq          (irq),
    .flag_q       (flag_q)
);

// File: tb/rtc_intr_status_tb_top.sv
`timescale 1ns/1ps
module rtc_intr_status_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    logic chk_en = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       irq_v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // independent model: [2] periodic, [1] alarm, [0] update ended
    logic [2:0] m_flags = 3'b000;
    logic [7:0] m_ctrl  = 8'h00;

    always #2 clk = ~clk;

    rtc_intr_status dut_i (
        .clk          (clk),
        .rst          (rst),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq)
    );

    function automatic logic m_irq();
        return |(m_flags & m_ctrl[6:4]);
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd11:   return m_ctrl;
            4'd12:   return {m_irq(), m_flags, 4'b0000};
            4'd13:   return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    // monitor: pops and compares in the middle of the cycle
    always @(negedge clk) begin
        if (chk_en && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.data || irq !== e.irq_v) begin
                failures++;
                $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                         e.tag, bus_rdata, irq, e.data, e.irq_v);
            end
        end
    end

    // driver: one cycle per call, entered just after a rising edge
    task automatic step(input logic [2:0] ev, input logic rd, input logic wr,
                        input logic [3:0] a, input logic [7:0] wd,
                        input logic chk, input string tag);
        exp_t e;
        {evt_periodic, evt_alarm, evt_update} = ev;
        bus_rd = rd;
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = wd;
        if (chk) begin
            e.data = m_read(a);
            e.irq_v = m_irq();
            e.tag = tag;
            exp_q.push_back(e);
            chk_en = 1'b1;
        end
        @(posedge clk);
        if (wr && a == 4'd11) m_ctrl = wd;
        m_flags = ((rd && a == 4'd12) ? 3'b000 : m_flags) | ev;
        #1;
        chk_en = 1'b0;
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        step(3'b000, 1'b1, 1'b0, a, 8'h00, 1'b1, tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        step(3'b000, 1'b0, 1'b1, a, d, 1'b0, "");
    endtask

    task automatic pulse(input logic [2:0] ev);
        step(ev, 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, "");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd_chk(4'd12, "R1 flags zero after reset");
        rd_chk(4'd11, "R1 control zero after reset");
        rd_chk(4'd13, "R8 valid byte");

        pulse(3'b100);
        rd_chk(4'd12, "R2 R7 periodic flag without enable");
        rd_chk(4'd12, "R5 flags cleared by read");

        pulse(3'b011);
        rd_chk(4'd13, "R3 irq low with enables clear");
        rd_chk(4'd12, "R2 alarm and update flags");

        wr_reg(4'd11, 8'h20);
        pulse(3'b010);
        rd_chk(4'd13, "R3 irq from enabled alarm");
        for (int k = 0; k < 5; k++) rd_chk(4'd13, "R4 irq held until read");
        rd_chk(4'd12, "R4 summary bit with alarm");
        rd_chk(4'd13, "R4 irq drops after read");

        pulse(3'b001);
        rd_chk(4'd13, "R3 update enable clear");
        wr_reg(4'd11, 8'h30);
        rd_chk(4'd13, "R3 enable after flag");
        wr_reg(4'd11, 8'h20);
        rd_chk(4'd13, "R3 enable removed");
        rd_chk(4'd12, "R5 update flag read");

        pulse(3'b100);
        step(3'b001, 1'b1, 1'b0, 4'd12, 8'h00, 1'b1, "R6 read returns pre-event state");
        rd_chk(4'd12, "R6 coincident event kept");
        rd_chk(4'd12, "R5 empty after second read");

        pulse(3'b111);
        wr_reg(4'd12, 8'h00);
        rd_chk(4'd12, "R9 write to flags keeps them");
        wr_reg(4'd12, 8'hFF);
        rd_chk(4'd12, "R9 write to flags sets nothing");

        wr_reg(4'd11, 8'h5A);
        rd_chk(4'd11, "R9 control readback");
        pulse(3'b100);
        rd_chk(4'd13, "R3 periodic enable bit 6");
        rd_chk(4'd12, "R3 summary with periodic");

        wr_reg(4'd13, 8'h00);
        rd_chk(4'd13, "R8 write to valid ignored");

        rst = 1'b1;
        @(posedge clk);
        m_flags = 3'b000;
        m_ctrl = 8'h00;
        #1 rst = 1'b0;
        rd_chk(4'd11, "R1 control cleared by reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule